// File: doc/BRIEF.md
# Broadcast Write Master for a Shared Backplane

This block sits between a node's local logic and a shared parallel backplane and turns local write requests into backplane write cycles. A request carries an address, a data word and a broadcast flag. A request counts as a broadcast when the flag is set or when its address falls inside a configured broadcast window. A broadcast goes out with a reserved address-modifier code from the user-defined range. Every other write goes out with an ordinary code.

A broadcast has many listeners and no single responder. The master therefore keeps address, data and strobe on the bus for a programmed number of clocks, long enough for the slowest listener to latch them. It then drives the shared acknowledge line itself for one clock. An ordinary write waits for a slave acknowledge and gives up with a bus-error pulse if none arrives in time.

After each cycle the master waits for the shared acknowledge line to fall before it takes the next request. Bus ownership is assumed to be held already.

Top module: `bcw_master`

## Requirements
- R1: With the broadcast flag set, the bus cycle carries address-modifier code 0x1A (inside the user range 0x10..0x1F), together with the request's address and data.
- R2: A write whose address lies in 0xF00000..0xF0FFFF is a broadcast (code 0x1A) even with the flag clear. A write outside that window with the flag clear uses code 0x0D.
- R3: During a broadcast the strobe stays high, with the self-acknowledge low, for exactly H clocks. H is the value of cfg_hold taken when the request is accepted, and a value of 0 selects 8.
- R4: After the hold, bus_ack_o is high for one clock while the strobe is still high. A slave acknowledge seen during the hold neither shortens nor lengthens it.
- R5: An ordinary write keeps the strobe high until bus_ack_i is sampled high. The master never drives bus_ack_o for it.
- R6: The strobe stays high for the one clock after the acknowledge, and is low in the clock after that.
- R7: Once the strobe is released, the master waits for bus_ack_i to be low. req_ready returns in the clock after bus_ack_i is sampled low.
- R8: If an ordinary write sees no acknowledge within 64 strobe clocks, the strobe drops and bus_err pulses high for one clock.
- R9: req_ready is low from acceptance until the master returns to idle. Requests presented in that time are ignored, and bus_addr, bus_am and bus_data keep their values.
- R10: After reset, req_ready is high and bus_strb, bus_ack_o and bus_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local write request valid |
| req_ready | output | 1 | Master idle and able to accept |
| req_addr | input | 24 | Write address |
| req_data | input | 32 | Write data |
| req_bcast | input | 1 | Request broadcast treatment |
| cfg_hold | input | 8 | Broadcast hold length in clocks (0 selects 8) |
| bus_addr | output | 24 | Backplane address |
| bus_am | output | 6 | Backplane address-modifier code |
| bus_data | output | 32 | Backplane data |
| bus_strb | output | 1 | Write strobe |
| bus_ack_o | output | 1 | Drive of the shared acknowledge line (self-acknowledge) |
| bus_ack_i | input | 1 | Sensed state of the shared acknowledge line |
| bus_err | output | 1 | One-clock pulse on ordinary-write timeout |

## Verification
The assertions assume that bus_ack_i is the wired-OR of the master's own bus_ack_o and any slave acknowledges. They also assume that slaves drop their acknowledge at some point after the strobe falls. The bench builds the acknowledge line exactly that way. Its modelled slave raises an acknowledge only while a strobe is high and holds it for a bounded number of clocks after release. The bench keeps req_valid high with altered data throughout each cycle to test that such requests are ignored.

// File: rtl/bcw_pkg.sv
package bcw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_REL,
    ST_DRAIN
  } bcw_state_t;
endpackage

// File: rtl/bcw_classify.sv
module bcw_classify #(
  parameter int AW = 24,
  parameter int AMW = 6,
  parameter logic [AW-1:0] WIN_BASE = 24'hF00000,
  parameter logic [AW-1:0] WIN_LAST = 24'hF0FFFF,
  parameter logic [AMW-1:0] BC_AM = 6'h1A,
  parameter logic [AMW-1:0] NORM_AM = 6'h0D
) (
  input  logic [AW-1:0]  addr,
  input  logic           bcast_flag,
  output logic           is_bc,
  output logic [AMW-1:0] am
);
  logic in_win;

  always_comb begin
    in_win = (addr >= WIN_BASE) && (addr <= WIN_LAST);
    is_bc  = bcast_flag | in_win;
    am     = is_bc ? BC_AM : NORM_AM;
  end
endmodule

// File: rtl/bcw_cnt.sv
module bcw_cnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= W'(1);
    else if (inc)  q <= q + W'(1);
  end
endmodule

// File: rtl/bcw_seq.sv
module bcw_seq
  import bcw_pkg::*;
#(
  parameter int CW = 9,
  parameter int TO_CYC = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          is_bc,
  input  logic [CW-1:0] hold_eff,
  input  logic [CW-1:0] cnt,
  input  logic          ack_i,
  output logic          ready,
  output logic          accept,
  output logic          cnt_inc,
  output logic          strb,
  output logic          ack_o,
  output logic          err
);
  localparam logic [CW-1:0] TO_LIM = CW'(TO_CYC);

  bcw_state_t    state_q;
  logic          bc_q;
  logic [CW-1:0] hold_q;

  assign ready   = (state_q == ST_IDLE);
  assign accept  = req_valid & ready;
  assign cnt_inc = (state_q == ST_DRIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      strb    <= 1'b0;
      ack_o   <= 1'b0;
      err     <= 1'b0;
      bc_q    <= 1'b0;
      hold_q  <= '0;
    end else begin
      err <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_DRIVE;
          strb    <= 1'b1;
          bc_q    <= is_bc;
          hold_q  <= hold_eff;
        end
        ST_DRIVE: begin
          if (bc_q) begin
            if (cnt == hold_q) begin
              state_q <= ST_REL;
              ack_o   <= 1'b1;
            end
          end else if (ack_i) begin
            state_q <= ST_REL;
          end else if (cnt == TO_LIM) begin
            state_q <= ST_DRAIN;
            strb    <= 1'b0;
            err     <= 1'b1;
          end
        end
        ST_REL: begin
          state_q <= ST_DRAIN;
          strb    <= 1'b0;
          ack_o   <= 1'b0;
        end
        default: if (!ack_i) state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  self_ack_strb_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> strb);
  // R5
  self_ack_bc_only_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> bc_q);
  // R6
  release_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> (!strb && !ack_o));
  // R7
  wait_ack_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && !strb && ack_i) |=> !ready);
endmodule

// File: rtl/bcw_master.sv
module bcw_master #(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int AMW = 6,
  parameter int HW = 8,
  parameter int DEF_HOLD = 8,
  parameter int TO_CYC = 64,
  parameter logic [AW-1:0] WIN_BASE = 24'hF00000,
  parameter logic [AW-1:0] WIN_LAST = 24'hF0FFFF,
  parameter logic [AMW-1:0] BC_AM = 6'h1A,
  parameter logic [AMW-1:0] NORM_AM = 6'h0D
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_data,
  input  logic           req_bcast,
  input  logic [HW-1:0]  cfg_hold,
  output logic [AW-1:0]  bus_addr,
  output logic [AMW-1:0] bus_am,
  output logic [DW-1:0]  bus_data,
  output logic           bus_strb,
  output logic           bus_ack_o,
  input  logic           bus_ack_i,
  output logic           bus_err
);
  localparam int TOW = $clog2(TO_CYC + 1);
  localparam int CW  = ((HW > TOW) ? HW : TOW) + 1;

  logic           is_bc;
  logic [AMW-1:0] am_sel;
  logic [CW-1:0]  hold_eff;
  logic [CW-1:0]  cnt;
  logic           accept;
  logic           cnt_inc;

  assign hold_eff = (cfg_hold == '0) ? CW'(DEF_HOLD) : CW'(cfg_hold);

  bcw_classify #(
    .AW(AW), .AMW(AMW), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST),
    .BC_AM(BC_AM), .NORM_AM(NORM_AM)
  ) u_cls (
    .addr(req_addr), .bcast_flag(req_bcast), .is_bc(is_bc), .am(am_sel)
  );

  bcw_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(accept), .inc(cnt_inc), .q(cnt)
  );

  bcw_seq #(.CW(CW), .TO_CYC(TO_CYC)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .is_bc(is_bc),
    .hold_eff(hold_eff), .cnt(cnt), .ack_i(bus_ack_i), .ready(req_ready),
    .accept(accept), .cnt_inc(cnt_inc), .strb(bus_strb), .ack_o(bus_ack_o),
    .err(bus_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_am   <= NORM_AM;
      bus_data <= '0;
    end else if (accept) begin
      bus_addr <= req_addr;
      bus_am   <= am_sel;
      bus_data <= req_data;
    end
  end

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_strb && $past(bus_strb)) |-> ($stable(bus_addr) && $stable(bus_data) && $stable(bus_am)));
  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && bus_strb));
  // R8
  err_normal_only_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_am == NORM_AM && !bus_strb));
  // R1
  self_ack_code_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack_o |-> (bus_am == BC_AM));
endmodule

// File: tb/test_bcw_master.sv
module test_bcw_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic        req_bcast = 1'b0;
  logic [7:0]  cfg_hold = '0;
  logic [23:0] bus_addr;
  logic [5:0]  bus_am;
  logic [31:0] bus_data;
  logic        bus_strb, bus_ack_o, bus_ack_i, bus_err;
  logic        slv_ack = 1'b0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;
  assign bus_ack_i = bus_ack_o | slv_ack;

  bcw_master i_bcw_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_bcast(req_bcast),
    .cfg_hold(cfg_hold), .bus_addr(bus_addr), .bus_am(bus_am),
    .bus_data(bus_data), .bus_strb(bus_strb), .bus_ack_o(bus_ack_o),
    .bus_ack_i(bus_ack_i), .bus_err(bus_err)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected {ready, strb, ack_o, err} in the current clock
  task automatic pins(string tag, logic [3:0] exp);
    chk(tag, {60'd0, req_ready, bus_strb, bus_ack_o, bus_err}, {60'd0, exp});
  endtask

  // ack_dly: clock of the strobe in which the slave acknowledges (0 = never)
  task automatic txn(logic [23:0] a, logic [31:0] d, bit bc, logic [7:0] h,
                     int ack_dly, bit stray);
    bit is_bc;
    int hold;
    is_bc = bc || (a >= 24'hF00000 && a <= 24'hF0FFFF);
    hold  = (h == 0) ? 8 : int'(h);
    pins("R10/R7 idle before request", 4'b1000);
    req_addr = a; req_data = d; req_bcast = bc; cfg_hold = h; req_valid = 1'b1;
    @(negedge clk);
    req_data = ~d; req_addr = a ^ 24'h000100; cfg_hold = 8'd2; // ignored request, R9
    chk(is_bc ? "R1 address" : "R2 address", {40'd0, bus_addr}, {40'd0, a});
    chk("R1 data", {32'd0, bus_data}, {32'd0, d});
    chk(is_bc ? "R1/R2 broadcast code" : "R2 normal code", {58'd0, bus_am},
        is_bc ? 64'h1A : 64'h0D);
    if (is_bc) begin
      for (int i = 1; i <= hold; i++) begin
        pins("R3 hold strobe", 4'b0100);
        if (stray && i == 1) slv_ack = 1'b1;
        @(negedge clk);
      end
      pins(stray ? "R4 self-ack despite slave ack" : "R4 self-ack", 4'b0110);
      @(negedge clk);
      pins("R6 release after self-ack", 4'b0000);
      if (stray) begin
        @(negedge clk);
        pins("R7 wait for ack low", 4'b0000);
        slv_ack = 1'b0;
      end
    end else if (ack_dly > 0) begin
      for (int i = 1; i <= ack_dly; i++) begin
        pins("R5 strobe until slave ack", 4'b0100);
        if (i == ack_dly) slv_ack = 1'b1;
        @(negedge clk);
      end
      pins("R6 strobe one clock after ack", 4'b0100);
      @(negedge clk);
      pins("R6 strobe released", 4'b0000);
      @(negedge clk);
      pins("R7 wait for ack low", 4'b0000);
      slv_ack = 1'b0;
    end else begin
      for (int i = 1; i <= 64; i++) begin
        pins("R8 strobe before timeout", 4'b0100);
        @(negedge clk);
      end
      pins("R8 error pulse", 4'b0001);
    end
    req_valid = 1'b0;
    @(negedge clk);
    pins("R7 ready after ack low", 4'b1000);
    chk("R9 data kept", {32'd0, bus_data}, {32'd0, d});
    chk("R9 address kept", {40'd0, bus_addr}, {40'd0, a});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    pins("R10 reset state", 4'b1000);
    txn(24'h001000, 32'hDEADBEEF, 1'b1, 8'd3, 0, 1'b0);
    txn(24'h001004, 32'h12345678, 1'b1, 8'd0, 0, 1'b0);
    txn(24'hF00010, 32'hCAFEF00D, 1'b0, 8'd1, 0, 1'b0);
    txn(24'h003000, 32'h0BADC0DE, 1'b1, 8'd5, 0, 1'b1);
    txn(24'h002000, 32'h55AA55AA, 1'b0, 8'd4, 2, 1'b0);
    txn(24'hF10000, 32'hA5A5A5A5, 1'b0, 8'd4, 1, 1'b0);
    txn(24'hEFFFFF, 32'h01020304, 1'b0, 8'd4, 5, 1'b0);
    txn(24'hF0FFFF, 32'h77777777, 1'b0, 8'd12, 0, 1'b0);
    txn(24'h004000, 32'h99999999, 1'b0, 8'd4, 0, 1'b0);
    txn(24'h005000, 32'h13572468, 1'b1, 8'd2, 0, 1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule